// File: doc/BRIEF.md
# Stepper Bridge Guard

This block is the enable and protection core of a two-channel H-bridge stepper driver. It takes the operator controls (a global run/standby level, a per-channel enable and direction, and a torque select) together with status flags from the analog side: a logic-supply-good flag, a motor-supply-good flag, an over-temperature trip flag with a separate cooled-down flag, and an overcurrent flag for each bridge. From these it produces, for each bridge, an enable and a forward-direction level for the gate driver. It also produces a core reset, a charge-pump run level, a one-bit current-scale code for the chopper and a fault indication.

Every asynchronous input passes through a two-flop synchroniser. Thermal and overcurrent events are held in separate latches that shut the whole device down. The overcurrent latch is released by the next rising edge of the standby input. The thermal latch is released only by a full high, low, high cycle of the standby input that ends while the cooled-down flag is set. Losing either supply holds the core in reset and clears both latches.

Top module: `stepper_guard`

## Requirements
- R1: While `rst_n` is low, and after its release while both supply flags are still low, `core_rst` is 1 and every other output is 0.
- R2: A channel whose enable input is 0 has both its bridge-enable and its forward output at 0, whatever its direction input is.
- R3: A channel whose enable input is 1, with the device running, has bridge-enable 1 and forward equal to its direction input (1 = current from the positive to the negative terminal).
- R4: With the standby input at 0, `pump_run` and both bridge enables are 0.
- R5: `trq_full` follows the torque input in every state (1 = full current, 0 = 71 % scale).
- R6: While either supply flag is 0, `core_rst` is 1 and all bridge enables and `pump_run` are 0; a later drop of either flag brings this back.
- R7: An over-temperature trip latches: `fault` goes to 1, and `pump_run` and both bridges go to 0, even after the trip flag falls.
- R8: The thermal latch clears only on a standby rise that follows a standby fall made while latched, and only if the cooled-down flag is 1 at that rise; the same sequence with the flag at 0 leaves it set.
- R9: A standby rise with no standby fall since the thermal trip does not clear the thermal latch.
- R10: An overcurrent on either bridge latches `fault` and turns off the pump and both bridges; the latch clears on the next standby rise at which no overcurrent flag is set.
- R11: `fault` is the OR of both latches, and each latch clears by its own rule; a standby cycle while still hot clears only the overcurrent latch.
- R12: A drop of either supply flag clears both fault latches.
- R13: A change of an input reaches the direct outputs two clock edges later, and a fault flag reaches `fault` three edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_in | input | 1 | 1 = run, 0 = standby |
| en_a_in | input | 1 | Channel A enable |
| en_b_in | input | 1 | Channel B enable |
| dir_a_in | input | 1 | Channel A direction |
| dir_b_in | input | 1 | Channel B direction |
| trq_in | input | 1 | Torque select, 1 = full |
| vlog_ok_in | input | 1 | Logic supply above its return level |
| vmot_ok_in | input | 1 | Motor supply above its return level |
| hot_in | input | 1 | Over-temperature trip |
| cool_in | input | 1 | Temperature back below the hysteresis level |
| ocp_a_in | input | 1 | Overcurrent on bridge A |
| ocp_b_in | input | 1 | Overcurrent on bridge B |
| br_en_a | output | 1 | Bridge A enable, 0 = all four switches off |
| br_fwd_a | output | 1 | Bridge A forward direction |
| br_en_b | output | 1 | Bridge B enable |
| br_fwd_b | output | 1 | Bridge B forward direction |
| core_rst | output | 1 | Supply-driven core reset |
| pump_run | output | 1 | Charge pump run |
| trq_full | output | 1 | Current scale code, 1 = 100 %, 0 = 71 % |
| fault | output | 1 | Any fault latch set |

## Verification
Direct outputs change two edges after an input, because of the synchroniser; the latches add one edge, so `fault` and the shutdown it causes appear three edges after a flag. The timing test samples on falling edges just before and just after each of these edges. Every other stimulus is held for six cycles before all eight outputs are compared with a model that the bench keeps at the level of the requirements, so the pipeline depth cannot alias a result.

// File: rtl/stepper_guard.sv
module stepper_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stby_in,
  input  logic en_a_in,
  input  logic en_b_in,
  input  logic dir_a_in,
  input  logic dir_b_in,
  input  logic trq_in,
  input  logic vlog_ok_in,
  input  logic vmot_ok_in,
  input  logic hot_in,
  input  logic cool_in,
  input  logic ocp_a_in,
  input  logic ocp_b_in,
  output logic br_en_a,
  output logic br_fwd_a,
  output logic br_en_b,
  output logic br_fwd_b,
  output logic core_rst,
  output logic pump_run,
  output logic trq_full,
  output logic fault
);
  localparam int NIN = 11;

  logic [NIN-1:0] raw;
  logic [NIN-1:0] pipe [SYNC_STAGES];
  logic [NIN-1:0] s;

  assign raw = {ocp_b_in, ocp_a_in, cool_in, hot_in, vmot_ok_in, vlog_ok_in,
                trq_in, dir_b_in, dir_a_in, en_b_in, en_a_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign s = pipe[SYNC_STAGES-1];

  logic en_a_s, en_b_s, dir_a_s, dir_b_s, trq_s, cool_s, hot_s, ocp_s, stby_s;
  logic pwr_ok;
  assign en_a_s  = s[0];
  assign en_b_s  = s[1];
  assign dir_a_s = s[2];
  assign dir_b_s = s[3];
  assign trq_s   = s[4];
  assign pwr_ok  = s[5] & s[6];
  assign hot_s   = s[7];
  assign cool_s  = s[8];
  assign ocp_s   = s[9] | s[10];

  logic stby_p1, stby_p2, stby_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stby_p1 <= 1'b0;
      stby_p2 <= 1'b0;
      stby_d  <= 1'b0;
    end else begin
      stby_p1 <= stby_in;
      stby_p2 <= stby_p1;
      stby_d  <= stby_p2;
    end
  end
  assign stby_s = stby_p2;

  logic stby_rise, stby_fall;
  assign stby_rise = stby_s & ~stby_d;
  assign stby_fall = ~stby_s & stby_d;

  logic th_lat, th_arm, oc_lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      th_lat <= 1'b0;
      th_arm <= 1'b0;
      oc_lat <= 1'b0;
    end else if (!pwr_ok) begin
      th_lat <= 1'b0;
      th_arm <= 1'b0;
      oc_lat <= 1'b0;
    end else begin
      if (hot_s)                            th_lat <= 1'b1;
      else if (stby_rise && th_arm && cool_s) th_lat <= 1'b0;

      if (stby_fall && th_lat) th_arm <= 1'b1;
      else if (stby_rise)      th_arm <= 1'b0;

      if (ocp_s)          oc_lat <= 1'b1;
      else if (stby_rise) oc_lat <= 1'b0;
    end
  end

  logic run;
  assign run      = stby_s & pwr_ok & ~th_lat & ~oc_lat;
  assign core_rst = ~pwr_ok;
  assign pump_run = run;
  assign br_en_a  = run & en_a_s;
  assign br_en_b  = run & en_b_s;
  assign br_fwd_a = run & en_a_s & dir_a_s;
  assign br_fwd_b = run & en_b_s & dir_b_s;
  assign trq_full = trq_s;
  assign fault    = th_lat | oc_lat;

  a_r2_disabled_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a_s |-> (!br_en_a && !br_fwd_a));
  a_r4_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_s |-> (!pump_run && !br_en_a && !br_en_b));
  a_r6_supply_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (!th_lat && !oc_lat));
  a_r7_thermal_shuts: assert property (@(posedge clk) disable iff (!rst_n)
    th_lat |-> (fault && !pump_run && !br_en_a && !br_en_b));
  a_r8_hot_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (th_lat && !cool_s && pwr_ok) |=> th_lat);
  a_r9_arm_needs_trip: assert property (@(posedge clk) disable iff (!rst_n)
    th_arm |-> th_lat);
  a_r10_oc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_lat && pwr_ok && !stby_rise) |=> oc_lat);
endmodule

// File: tb/sim_stepper_guard.sv
module sim_stepper_guard;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic stby = 0, ena = 0, enb = 0, dira = 0, dirb = 0, trq = 0;
  logic vlog = 0, vmot = 0, hot = 0, cool = 0, ocpa = 0, ocpb = 0;
  logic br_en_a, br_fwd_a, br_en_b, br_fwd_b, core_rst, pump_run, trq_full, fault;

  stepper_guard u0 (
    .clk(clk), .rst_n(rst_n), .stby_in(stby), .en_a_in(ena), .en_b_in(enb),
    .dir_a_in(dira), .dir_b_in(dirb), .trq_in(trq), .vlog_ok_in(vlog),
    .vmot_ok_in(vmot), .hot_in(hot), .cool_in(cool), .ocp_a_in(ocpa),
    .ocp_b_in(ocpb), .br_en_a(br_en_a), .br_fwd_a(br_fwd_a), .br_en_b(br_en_b),
    .br_fwd_b(br_fwd_b), .core_rst(core_rst), .pump_run(pump_run),
    .trq_full(trq_full), .fault(fault)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_th = 0, m_oc = 0, m_arm = 0, p_stby = 0;

  function automatic logic [7:0] outv();
    return {core_rst, pump_run, br_en_a, br_fwd_a, br_en_b, br_fwd_b, trq_full, fault};
  endfunction

  function automatic logic [7:0] expv();
    logic pwr, run;
    pwr = vlog & vmot;
    run = stby & pwr & ~m_th & ~m_oc;
    return {~pwr, run, run & ena, run & ena & dira, run & enb, run & enb & dirb,
            trq, m_th | m_oc};
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b, expected %b", tag, got, exp);
    end
  endtask

  task automatic settle(string tag);
    bit pwr, rise, fall, th0;
    pwr  = vlog & vmot;
    rise = !p_stby && stby;
    fall = p_stby && !stby;
    th0  = m_th;
    if (!pwr) begin
      m_th = 0; m_oc = 0; m_arm = 0;
    end else begin
      if (hot) m_th = 1;
      else if (rise && m_arm && cool) m_th = 0;
      if (fall && th0) m_arm = 1;
      else if (rise) m_arm = 0;
      if (ocpa || ocpb) m_oc = 1;
      else if (rise) m_oc = 0;
    end
    p_stby = stby;
    repeat (6) @(negedge clk);
    chk(tag, outv(), expv());
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", outv(), 8'b1000_0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", outv(), 8'b1000_0000);

    vlog = 1; vmot = 1; cool = 1;
    settle("R6 supplies up");
    for (int v = 0; v < 64; v++) begin
      {stby, ena, enb, dira, dirb, trq} = 6'(v);
      settle("R2 R3 R4 R5 sweep");
    end

    stby = 1; ena = 1; enb = 1; dira = 1; dirb = 0; trq = 1;
    settle("R3 run");
    for (int p = 0; p < 3; p++) begin
      {vlog, vmot} = 2'(p);
      settle("R6 supply low");
    end
    vlog = 1; vmot = 1; settle("R6 restored");
    vmot = 0; settle("R6 later drop");
    vmot = 1; settle("R6 restored again");

    trq = 0;
    @(negedge clk); chk("R13 one edge", {7'b0, trq_full}, 8'd1);
    @(negedge clk); chk("R13 two edges", {7'b0, trq_full}, 8'd0);
    settle("R5 settled");
    ocpa = 1;
    @(negedge clk); @(negedge clk); chk("R13 fault two edges", {7'b0, fault}, 8'd0);
    @(negedge clk); chk("R13 fault three edges", {7'b0, fault}, 8'd1);
    settle("R10 latched");
    ocpa = 0; settle("R10 held after flag");
    stby = 0; settle("R10 held in standby");
    stby = 1; settle("R10 cleared by rise");
    ocpb = 1; settle("R10 bridge B");
    stby = 0; settle("R10 B standby");
    stby = 1; settle("R10 rise with flag still set");
    ocpb = 0; settle("R10 B held");
    stby = 0; settle("R10 B standby again");
    stby = 1; settle("R10 B cleared");

    hot = 1; cool = 0; settle("R7 trip");
    hot = 0; settle("R7 held after flag");
    stby = 0; settle("R8 standby while hot");
    stby = 1; settle("R8 rise while hot keeps latch");
    stby = 0; settle("R8 standby again");
    cool = 1; settle("R8 cooled in standby");
    stby = 1; settle("R8 cleared");

    stby = 0; settle("R9 standby");
    hot = 1; cool = 0; settle("R9 trip in standby");
    hot = 0; cool = 1; settle("R9 cooled");
    stby = 1; settle("R9 rise without fall keeps latch");
    stby = 0; settle("R9 fall");
    stby = 1; settle("R9 cleared");

    hot = 1; cool = 0; ocpb = 1; settle("R11 both latched");
    hot = 0; ocpb = 0; settle("R11 both held");
    stby = 0; settle("R11 standby");
    stby = 1; settle("R11 only overcurrent cleared");
    stby = 0; cool = 1; settle("R11 standby cool");
    stby = 1; settle("R11 thermal cleared");

    ocpa = 1; hot = 1; cool = 0; settle("R12 both set");
    ocpa = 0; hot = 0; cool = 1; settle("R12 held");
    vlog = 0; settle("R12 supply drop");
    vlog = 1; settle("R12 latches gone");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule